// File: doc/BRIEF.md
# Ultrasonic Ranging Sequencer

This block runs an ultrasonic distance sensor with no help from the host. It drives a trigger pulse of fixed width to the sensor. It then waits for the sensor's echo line to rise and times how long the echo stays high, in whole microseconds. When the echo returns low, the block latches the count and tells the host with a one-cycle event and a sticky flag. It then waits out a settling hold-off so that the acoustic burst can die away, and fires the next trigger by itself.

The clock frequency is a parameter. A restartable prescaler derives the microsecond time base from it, and all intervals are counted in microseconds. Every measurement ends in one of two ways: with a valid count, or with an all-ones code. The all-ones code is stored when no echo arrives within the wait limit, or when the echo stays high past the longest range allowed. The host can stop the loop by dropping the enable. The cycle already under way still completes, including its hold-off, and the block then parks with the trigger low.

Top module: `sonar_ranger`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `trig_o`, `range_o`, `evt_o` and `evt_flag_o` are all zero.
- R2: Each trigger pulse holds `trig_o` high for exactly TRIG_US×(CLK_HZ/1e6) clock cycles.
- R3: The echo line passes through a two-flop synchronizer. Timing starts on the synchronized rising edge that follows the end of the trigger. If the echo stays high for L cycles, the stored count is floor((L−1)/(CLK_HZ/1e6)).
- R4: `range_o` changes only on the cycle in which `evt_o` is high. At all other times it holds the last result.
- R5: Each stored result comes with `evt_o` high for exactly one cycle. `evt_flag_o` is set on that same cycle.
- R6: `evt_flag_o` stays set until a cycle with `ack_i` high, which clears it on the next edge. A new event on that same edge keeps it set.
- R7: While enabled, the next trigger rises exactly HOLD_US×(CLK_HZ/1e6) cycles after `evt_o` rises.
- R8: If no echo rise is seen within WAIT_US microseconds of the trigger falling, `range_o` becomes all ones. This happens, with the event, exactly WAIT_US×(CLK_HZ/1e6) cycles after the fall. The hold-off follows.
- R9: If the echo count would pass MAX_COUNT, the measurement ends with `range_o` all ones and an event. An echo edge that arrives during the hold-off has no effect.
- R10: With `en_i` low and the block idle, `trig_o` stays low. Dropping `en_i` mid-cycle still lets the measurement and its hold-off complete, and no further trigger is issued.
- R11: From idle, `trig_o` rises on the first clock edge at which `en_i` is seen high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock at CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the trigger/measure/hold-off loop |
| echo_i | input | 1 | Raw echo line from the sensor (asynchronous) |
| ack_i | input | 1 | Host acknowledge, clears the sticky flag |
| trig_o | output | 1 | Trigger line to the sensor |
| range_o | output | RES_W | Last roundtrip time in microseconds, all ones on timeout |
| evt_o | output | 1 | One-cycle pulse when a new result is stored |
| evt_flag_o | output | 1 | Sticky result-ready flag |

## Verification
Several properties are checked on every cycle. The trigger-width counter confirms that no pulse runs short or long. The result register may move only together with the event pulse. The event must be a single cycle and must always come with the sticky flag. The flag cannot drop without an acknowledge, and any non-timeout result must lie within MAX_COUNT. Other behaviour only the bench scenarios can show: the exact microsecond count for a given echo width, the cycle-exact hold-off and no-echo timeouts, and the parking behaviour after enable drops. For these the bench sets up specific echo timings and compares every output against its behavioural model.

// File: rtl/sr_pkg.sv
package sr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TRIG,
      ST_WAIT,
      ST_MEAS,
      ST_HOLD
   } sr_state_e;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/sr_sync_edge.sv
module sr_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES:0] sh_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sr_sync_edge: at least two synchronizer stages are required");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-1:0], d_i};
   end

   assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
   assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/sr_us_tick.sv
module sr_us_tick #(
   parameter int unsigned CYC_PER_US = 100
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   output logic tick_o
);
   generate
      if (CYC_PER_US == 1) begin : g_pass
         logic unused_w;
         assign unused_w = clk_i ^ rst_ni ^ clr_i;
         assign tick_o   = 1'b1;
      end else begin : g_div
         localparam int unsigned PW = $clog2(CYC_PER_US);
         logic [PW-1:0] pre_q;
         assign tick_o = (pre_q == PW'(CYC_PER_US - 1));
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)               pre_q <= '0;
            else if (clr_i || tick_o)  pre_q <= '0;
            else                       pre_q <= pre_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/sr_notify.sv
module sr_notify (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fire_i,
   input  logic ack_i,
   output logic evt_o,
   output logic flag_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         evt_o  <= 1'b0;
         flag_o <= 1'b0;
      end else begin
         evt_o <= fire_i;
         if (fire_i)     flag_o <= 1'b1;
         else if (ack_i) flag_o <= 1'b0;
      end
   end
endmodule

// File: rtl/sonar_ranger.sv
module sonar_ranger #(
   parameter int unsigned CLK_HZ    = 100_000_000,
   parameter int unsigned TRIG_US   = 10,
   parameter int unsigned WAIT_US   = 30_000,
   parameter int unsigned HOLD_US   = 30_000,
   parameter int unsigned MAX_COUNT = 25_000,
   parameter int unsigned RES_W     = 16,
   parameter int unsigned SYNC_N    = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             echo_i,
   input  logic             ack_i,
   output logic             trig_o,
   output logic [RES_W-1:0] range_o,
   output logic             evt_o,
   output logic             evt_flag_o
);
   import sr_pkg::*;

   localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
   localparam int unsigned US_MAX     = max4(TRIG_US, WAIT_US, HOLD_US, MAX_COUNT + 1);
   localparam int unsigned US_W       = $clog2(US_MAX + 1);
   localparam logic [RES_W-1:0] TIMEOUT_CODE = '1;

   generate
      if (CYC_PER_US == 0 || (CLK_HZ % 1_000_000) != 0) begin : g_bad_clk
         $error("sonar_ranger: CLK_HZ must be a nonzero multiple of 1 MHz");
      end
      if (TRIG_US == 0 || WAIT_US == 0 || HOLD_US == 0) begin : g_bad_iv
         $error("sonar_ranger: intervals must be at least one microsecond");
      end
      if (RES_W > 31 || MAX_COUNT >= (2 ** RES_W) - 1) begin : g_bad_res
         $error("sonar_ranger: MAX_COUNT must leave the all-ones code free");
      end
   endgenerate

   sr_state_e        st_q, st_d;
   logic [US_W-1:0]  cnt_q, cnt_d;
   logic [RES_W-1:0] res_q, res_d;
   logic             tick, clr, fire, rise, fall;

   sr_sync_edge #(.STAGES(SYNC_N)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (echo_i),
      .rise_o (rise),
      .fall_o (fall)
   );

   sr_us_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .tick_o (tick)
   );

   sr_notify u_note (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fire_i (fire),
      .ack_i  (ack_i),
      .evt_o  (evt_o),
      .flag_o (evt_flag_o)
   );

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      res_d = res_q;
      clr   = 1'b0;
      fire  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (en_i) begin
               st_d  = ST_TRIG;
               cnt_d = '0;
               clr   = 1'b1;
            end
         end
         ST_TRIG: begin
            if (tick) begin
               if (cnt_q == US_W'(TRIG_US - 1)) begin
                  st_d  = ST_WAIT;
                  cnt_d = '0;
                  clr   = 1'b1;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
         end
         ST_WAIT: begin
            if (rise) begin
               st_d  = ST_MEAS;
               cnt_d = '0;
               clr   = 1'b1;
            end else if (tick) begin
               if (cnt_q == US_W'(WAIT_US - 1)) begin
                  res_d = TIMEOUT_CODE;
                  fire  = 1'b1;
                  st_d  = ST_HOLD;
                  cnt_d = '0;
                  clr   = 1'b1;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
         end
         ST_MEAS: begin
            if (fall) begin
               res_d = RES_W'(cnt_q);
               fire  = 1'b1;
               st_d  = ST_HOLD;
               cnt_d = '0;
               clr   = 1'b1;
            end else if (tick) begin
               if (cnt_q == US_W'(MAX_COUNT)) begin
                  res_d = TIMEOUT_CODE;
                  fire  = 1'b1;
                  st_d  = ST_HOLD;
                  cnt_d = '0;
                  clr   = 1'b1;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
         end
         ST_HOLD: begin
            if (tick) begin
               if (cnt_q == US_W'(HOLD_US - 1)) begin
                  st_d  = en_i ? ST_TRIG : ST_IDLE;
                  cnt_d = '0;
                  clr   = 1'b1;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
         end
         default: begin
            st_d  = ST_IDLE;
            cnt_d = '0;
            clr   = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         res_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         res_q <= res_d;
      end
   end

   assign trig_o  = (st_q == ST_TRIG);
   assign range_o = res_q;
endmodule

// File: rtl/sr_ranger_chk.sv
module sr_ranger_chk #(
   parameter int unsigned TRIG_CYC  = 1000,
   parameter int unsigned MAX_COUNT = 25_000,
   parameter int unsigned RES_W     = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             ack_i,
   input logic             trig_o,
   input logic [RES_W-1:0] range_o,
   input logic             evt_o,
   input logic             evt_flag_o
);
   int unsigned hi_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     hi_cnt <= 0;
      else if (trig_o) hi_cnt <= hi_cnt + 1;
      else             hi_cnt <= 0;
   end

   // R2
   trig_not_long_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_o |-> hi_cnt < TRIG_CYC);

   // R2
   trig_full_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(trig_o) |-> hi_cnt == TRIG_CYC);

   // R4
   result_moves_with_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(range_o) |-> evt_o);

   // R5
   evt_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_o |=> !evt_o);

   // R5
   evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_o |-> evt_flag_o);

   // R6
   flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_flag_o && !ack_i) |=> evt_flag_o);

   // R9
   result_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_o && range_o != '1) |-> range_o <= RES_W'(MAX_COUNT));
endmodule

bind sonar_ranger sr_ranger_chk #(
   .TRIG_CYC  (TRIG_US * (CLK_HZ / 1_000_000)),
   .MAX_COUNT (MAX_COUNT),
   .RES_W     (RES_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .ack_i      (ack_i),
   .trig_o     (trig_o),
   .range_o    (range_o),
   .evt_o      (evt_o),
   .evt_flag_o (evt_flag_o)
);

// File: tb/tb_sonar_ranger.sv
module tb_sonar_ranger;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_HZ     = 4_000_000;
   localparam int CPU        = CLK_HZ / 1_000_000;
   localparam int TRIG_US    = 10;
   localparam int WAIT_US    = 60;
   localparam int HOLD_US    = 40;
   localparam int MAX_COUNT  = 50;
   localparam int RES_W      = 8;
   localparam int ONES       = (1 << RES_W) - 1;

   logic clk = 1'b0;
   logic rst_n, en, echo, ack;
   logic trig, evt, flag;
   logic [RES_W-1:0] res;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sonar_ranger #(
      .CLK_HZ(CLK_HZ), .TRIG_US(TRIG_US), .WAIT_US(WAIT_US), .HOLD_US(HOLD_US),
      .MAX_COUNT(MAX_COUNT), .RES_W(RES_W), .SYNC_N(2)
   ) dut (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .echo_i(echo), .ack_i(ack),
      .trig_o(trig), .range_o(res), .evt_o(evt), .evt_flag_o(flag)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // behavioural reference model: 0 idle, 1 trigger, 2 wait, 3 measure, 4 hold
   int m_st, m_cnt, m_pre, m_res;
   bit m_evt, m_flag, e1, e2, e3;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_pre = 0; m_res = 0;
         m_evt = 0; m_flag = 0; e1 = 0; e2 = 0; e3 = 0;
      end else begin
         bit rise, fall, tick, clr, fire;
         rise = e2 && !e3;
         fall = !e2 && e3;
         tick = (m_pre == CPU - 1);
         clr  = 0;
         fire = 0;
         case (m_st)
            0: if (en) begin m_st = 1; m_cnt = 0; clr = 1; end
            1: if (tick) begin
                  if (m_cnt == TRIG_US - 1) begin m_st = 2; m_cnt = 0; clr = 1; end
                  else m_cnt++;
               end
            2: if (rise) begin m_st = 3; m_cnt = 0; clr = 1; end
               else if (tick) begin
                  if (m_cnt == WAIT_US - 1) begin
                     m_res = ONES; fire = 1; m_st = 4; m_cnt = 0; clr = 1;
                  end else m_cnt++;
               end
            3: if (fall) begin m_res = m_cnt; fire = 1; m_st = 4; m_cnt = 0; clr = 1; end
               else if (tick) begin
                  if (m_cnt == MAX_COUNT) begin
                     m_res = ONES; fire = 1; m_st = 4; m_cnt = 0; clr = 1;
                  end else m_cnt++;
               end
            default: if (tick) begin
                  if (m_cnt == HOLD_US - 1) begin m_st = en ? 1 : 0; m_cnt = 0; clr = 1; end
                  else m_cnt++;
               end
         endcase
         m_pre = (clr || tick) ? 0 : m_pre + 1;
         m_evt = fire;
         if (fire) m_flag = 1;
         else if (ack) m_flag = 0;
         e3 = e2; e2 = e1; e1 = echo;
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 trigger vs model", int'(trig), int'(m_st == 1));
         chk("R4 result vs model", int'(res), m_res);
         chk("R5 event vs model", int'(evt), int'(m_evt));
         chk("R6 flag vs model", int'(flag), int'(m_flag));
      end
   end

   initial begin
      repeat (100_000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic wait_trig_rise();
      do @(negedge clk); while (!trig);
   endtask
   task automatic wait_trig_fall();
      do @(negedge clk); while (trig);
   endtask
   task automatic wait_evt();
      do @(negedge clk); while (!evt);
   endtask
   task automatic echo_pulse(input int dly, input int len);
      cyc(dly);
      echo = 1'b1;
      cyc(len);
      echo = 1'b0;
   endtask

   initial begin
      int w, g;
      rst_n = 1'b0; en = 1'b0; echo = 1'b0; ack = 1'b0;
      cyc(3);
      // R1 reset state
      chk("R1 trig", int'(trig), 0);
      chk("R1 range", int'(res), 0);
      chk("R1 evt", int'(evt), 0);
      chk("R1 flag", int'(flag), 0);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 trig after reset", int'(trig), 0);

      // R10 idle with enable low
      w = 0;
      repeat (20) begin @(negedge clk); if (trig) w++; end
      chk("R10 idle trigger count", w, 0);

      // R11 start latency, R2 width
      en = 1'b1;
      g = 0;
      do begin @(negedge clk); g++; end while (!trig);
      chk("R11 enable to trigger", g, 1);
      w = 0;
      while (trig) begin w++; @(negedge clk); end
      chk("R2 trigger width", w, TRIG_US * CPU);

      // R3 measured count, R5 event
      echo_pulse(5, 4 * 7 + 2);
      wait_evt();
      chk("R3 count 7", int'(res), 7);
      chk("R5 flag with event", int'(flag), 1);

      // R7 hold-off gap
      g = 0;
      while (!trig) begin @(negedge clk); g++; end
      chk("R7 hold-off gap", g, HOLD_US * CPU);
      wait_trig_fall();

      echo_pulse(3, 4 * 3 + 2);
      wait_evt();
      chk("R3 count 3", int'(res), 3);
      chk("R6 flag kept without ack", int'(flag), 1);
      cyc(2);
      ack = 1'b1;
      cyc(1);
      ack = 1'b0;
      chk("R6 flag cleared by ack", int'(flag), 0);
      chk("R4 result held", int'(res), 3);

      // R8 no echo
      wait_trig_rise();
      wait_trig_fall();
      g = 0;
      while (!evt) begin @(negedge clk); g++; end
      chk("R8 no-echo timeout code", int'(res), ONES);
      chk("R8 no-echo timeout delay", g, WAIT_US * CPU);

      // R9 echo too long, late fall during hold-off
      wait_trig_rise();
      wait_trig_fall();
      cyc(2);
      echo = 1'b1;
      wait_evt();
      chk("R9 long echo code", int'(res), ONES);
      cyc(100);
      echo = 1'b0;
      cyc(20);
      chk("R9 fall in hold-off ignored", int'(res), ONES);

      // R10 enable dropped mid-measurement
      wait_trig_rise();
      wait_trig_fall();
      cyc(4);
      echo = 1'b1;
      en = 1'b0;
      cyc(4 * 5 + 2);
      echo = 1'b0;
      wait_evt();
      chk("R10 measurement completes", int'(res), 5);
      w = 0;
      repeat (400) begin @(negedge clk); if (trig) w++; end
      chk("R10 parked trigger count", w, 0);

      en = 1'b1;
      g = 0;
      do begin @(negedge clk); g++; end while (!trig);
      chk("R11 restart latency", g, 1);
      wait_trig_fall();
      echo_pulse(1, 2);
      wait_evt();
      chk("R3 shortest echo", int'(res), 0);

      cyc(5);
      finish_run();
   end
endmodule